// File: doc/BRIEF.md
# Sector Lock and Protection Controller

This block holds one lock bit for every erase sector of a 4M-word flash array and decides whether a program or erase aimed at a word address may go ahead. It watches the stream of command writes (address, data, write strobe) and recognises the lock/unlock sequence. It decodes any 22-bit word address into a sector number and a bank number over a map that has small boot sectors at both ends. It answers lock-status queries and applies a write-protect pin that overrides every lock bit.

The main command decoder issues an operation request: a program, a sector erase or a chip erase. One cycle later it receives either a grant pulse or a reject pulse. With a granted erase it also receives an erase-enable mask of the sectors that may be cleared. The array and the timing of the embedded algorithms stay outside the block.

Top module: `sector_guard`

## Requirements
- R1: After reset every sector is locked, so with `wp_n` high a query of any sector returns 01h.
- R2: A lock/unlock sequence is two command writes with data 60h at any address, then a write of 60h at an address inside the target sector. Address bit 6 of that write sets the action: 1 unlocks the sector and 0 locks it. The new lock state shows on the query port from the cycle after that write.
- R3: After the third write, each further write of 60h locks or unlocks the sector it addresses, without the two leading writes. A write of F0h ends the sequence, and a single 60h write after that changes no lock bit.
- R4: Any command write whose data is neither 60h nor F0h aborts a sequence in progress. A 60h write that follows the abort counts as the first write of a new sequence and changes no lock bit.
- R5: Sector decode works as follows. Word addresses 000000h–007FFFh give sectors 0–3, each 8K words in size. Addresses 3F8000h–3FFFFFh give sectors 130–133, each 8K words in size. Every other 32K-word block at 008000h + k·8000h gives sector 4 + k. There are 134 sectors.
- R6: The bank number is address bits 21:20, so each bank spans a quarter of the address space: 0 for 000000h–0FFFFFh up to 3 for 300000h–3FFFFFh.
- R7: While `wp_n` is low every sector reports and behaves as protected. While it is high the individual lock bits apply, and driving it low does not alter those bits.
- R8: `query_code` is 01h for a protected sector and 00h for an unprotected one, with no delay from `query_addr`.
- R9: An operation is presented by holding `op_valid` for one cycle, with `op_kind` 0 = program, 1 = sector erase, 2 = chip erase and 3 = no operation. In the following cycle, for one cycle only, exactly one response appears. A program or sector erase to a protected sector raises `op_reject` with a zero mask. To an unprotected sector it raises `op_grant`, with a zero mask for a program and a mask holding only that sector's bit for a sector erase. Code 3 raises neither.
- R10: A chip erase sets `erase_mask` bit n exactly for each unprotected sector n. It raises `op_grant` if that mask is nonzero and `op_reject` if every sector is protected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_we | input | 1 | One-cycle strobe of a command write |
| cmd_addr | input | 22 | Word address of the command write |
| cmd_data | input | 8 | Data of the command write |
| wp_n | input | 1 | Write-protect pin, low protects all sectors |
| op_valid | input | 1 | Operation request strobe |
| op_kind | input | 2 | 0 program, 1 sector erase, 2 chip erase, 3 none |
| op_addr | input | 22 | Target word address of the operation |
| query_addr | input | 22 | Address whose sector is queried |
| query_sector | output | 8 | Sector number of `query_addr` |
| query_bank | output | 2 | Bank number of `query_addr` |
| query_code | output | 8 | 01h protected, 00h unprotected |
| op_grant | output | 1 | One-cycle permit pulse |
| op_reject | output | 1 | One-cycle refusal pulse |
| erase_mask | output | 134 | Sectors enabled for erase, valid with the response |

## Verification
The bench drives random command streams against a model of the lock bits and the sequence state. It aims at the edges of the sector map: the last 8K sector at the bottom, the first 32K sector, the last 32K sector below the top boot area, and the top boot sectors. A decoder that treats the map as uniform, or that misplaces the top boot area, reports the wrong sector number and locks the wrong bit. Directed cases cover the repeat-without-reentry path, the exit and abort rules, a chip erase with every sector protected, and `wp_n` falling and rising around unlocked sectors. A design that left the sequence armed after F0h, or that let the pin erase the lock bits, would show a changed query code where none is expected.

// File: rtl/sector_guard.sv
module sector_guard #(
  parameter int ADDR_W  = 22,
  parameter int LARGE_W = 15,
  parameter int SMALL_W = 13,
  parameter int DATA_W  = 8,
  parameter int ACT_BIT = 6,
  parameter logic [7:0] CMD_LOCK = 8'h60,
  parameter logic [7:0] CMD_EXIT = 8'hF0,
  localparam int NBLK  = 1 << (ADDR_W - LARGE_W),
  localparam int SUBS  = 1 << (LARGE_W - SMALL_W),
  localparam int NSEC  = NBLK - 2 + 2 * SUBS,
  localparam int SEC_W = $clog2(NSEC)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_we,
  input  logic [ADDR_W-1:0] cmd_addr,
  input  logic [DATA_W-1:0] cmd_data,
  input  logic              wp_n,
  input  logic              op_valid,
  input  logic [1:0]        op_kind,
  input  logic [ADDR_W-1:0] op_addr,
  input  logic [ADDR_W-1:0] query_addr,
  output logic [SEC_W-1:0]  query_sector,
  output logic [1:0]        query_bank,
  output logic [DATA_W-1:0] query_code,
  output logic              op_grant,
  output logic              op_reject,
  output logic [NSEC-1:0]   erase_mask
);

  typedef enum logic [1:0] {S_IDLE, S_ONE, S_LIVE} seq_t;
  localparam logic [1:0] K_PROG = 2'd0, K_SECT = 2'd1, K_CHIP = 2'd2;

  function automatic logic [SEC_W-1:0] sec_of(input logic [ADDR_W-1:0] a);
    logic [ADDR_W-LARGE_W-1:0] blk;
    logic [LARGE_W-SMALL_W-1:0] sub;
    blk = a[ADDR_W-1:LARGE_W];
    sub = a[LARGE_W-1:SMALL_W];
    if (blk == '0)
      return SEC_W'(sub);
    else if (&blk)
      return SEC_W'(NBLK - 2 + SUBS) + SEC_W'(sub);
    else
      return SEC_W'(blk) + SEC_W'(SUBS - 1);
  endfunction

  seq_t            st;
  logic [NSEC-1:0] lock_q;
  logic [NSEC-1:0] prot;
  logic [NSEC-1:0] op_sel;
  logic [SEC_W-1:0] cmd_sec, op_sec;
  logic            hit;

  assign cmd_sec = sec_of(cmd_addr);
  assign op_sec  = sec_of(op_addr);
  assign op_sel  = NSEC'(1) << op_sec;
  assign hit     = cmd_we && (cmd_data == DATA_W'(CMD_LOCK)) && (st == S_LIVE);
  assign prot    = wp_n ? lock_q : '1;

  assign query_sector = sec_of(query_addr);
  assign query_bank   = query_addr[ADDR_W-1 -: 2];
  assign query_code   = {{(DATA_W-1){1'b0}}, prot[query_sector]};

  always_ff @(posedge clk) begin
    if (!rst_n)
      st <= S_IDLE;
    else if (cmd_we) begin
      if (cmd_data == DATA_W'(CMD_LOCK))
        st <= (st == S_IDLE) ? S_ONE : S_LIVE;
      else
        st <= S_IDLE;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)
      lock_q <= '1;
    else if (hit)
      lock_q[cmd_sec] <= ~cmd_addr[ACT_BIT];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      op_grant   <= 1'b0;
      op_reject  <= 1'b0;
      erase_mask <= '0;
    end else begin
      op_grant   <= 1'b0;
      op_reject  <= 1'b0;
      erase_mask <= '0;
      if (op_valid) begin
        case (op_kind)
          K_PROG: begin
            op_grant  <= ~prot[op_sec];
            op_reject <= prot[op_sec];
          end
          K_SECT: begin
            op_grant   <= ~prot[op_sec];
            op_reject  <= prot[op_sec];
            erase_mask <= prot[op_sec] ? '0 : op_sel;
          end
          K_CHIP: begin
            op_grant   <= ~&prot;
            op_reject  <= &prot;
            erase_mask <= ~prot;
          end
          default: ;
        endcase
      end
    end
  end

  a_r1_reset_locked: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(rst_n) |-> &lock_q);

  a_r2_lock_needs_write: assert property (@(posedge clk) disable iff (!rst_n)
    !cmd_we |=> $stable(lock_q));

  a_r3_exit_idle: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_we && cmd_data == DATA_W'(CMD_EXIT) |=> st == S_IDLE);

  a_r4_abort_idle: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_we && cmd_data != DATA_W'(CMD_LOCK) && cmd_data != DATA_W'(CMD_EXIT) |=> st == S_IDLE);

  a_r7_pin_blocks_grant: assert property (@(posedge clk) disable iff (!rst_n)
    op_valid && !wp_n |=> !op_grant);

  a_r9_single_response: assert property (@(posedge clk) disable iff (!rst_n)
    !(op_grant && op_reject));

  a_r9_sector_mask_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    op_valid && op_kind == K_SECT |=> $onehot0(erase_mask));

  a_r10_chip_all_protected: assert property (@(posedge clk) disable iff (!rst_n)
    op_valid && op_kind == K_CHIP && !wp_n |=> op_reject && erase_mask == '0);

endmodule

// File: tb/sector_guard_test.sv
module sector_guard_test;
  localparam int NS = 134;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rst_n = 1'b0, cmd_we = 1'b0, wp_n = 1'b1, op_valid = 1'b0;
  logic [21:0] cmd_addr = '0, op_addr = '0, query_addr = '0;
  logic [7:0] cmd_data = '0;
  logic [1:0] op_kind = '0;
  logic [7:0] query_sector, query_code;
  logic [1:0] query_bank;
  logic op_grant, op_reject;
  logic [NS-1:0] erase_mask;

  sector_guard uut (
    .clk(clk), .rst_n(rst_n), .cmd_we(cmd_we), .cmd_addr(cmd_addr), .cmd_data(cmd_data),
    .wp_n(wp_n), .op_valid(op_valid), .op_kind(op_kind), .op_addr(op_addr),
    .query_addr(query_addr), .query_sector(query_sector), .query_bank(query_bank),
    .query_code(query_code), .op_grant(op_grant), .op_reject(op_reject),
    .erase_mask(erase_mask)
  );

  int checks = 0, fails = 0, mst = 0;
  bit [NS-1:0] mlock = '1;
  bit done = 0;

  function automatic int esec(bit [21:0] a);
    if (a < 22'h008000) return int'(a >> 13);
    if (a >= 22'h3F8000) return 130 + int'((a - 22'h3F8000) >> 13);
    return 4 + int'((a - 22'h008000) >> 15);
  endfunction

  function automatic bit [NS-1:0] mprot();
    return wp_n ? mlock : '1;
  endfunction

  function automatic bit [21:0] raddr();
    case ($urandom % 3)
      0: return {7'h00, 15'($urandom)};
      1: return {7'h7F, 15'($urandom)};
      default: return 22'($urandom);
    endcase
  endfunction

  task automatic chk(input bit ok, input string msg);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s", msg);
    end
  endtask

  task automatic wr(input bit [21:0] a, input bit [7:0] d);
    @(negedge clk);
    cmd_we = 1'b1; cmd_addr = a; cmd_data = d;
    @(negedge clk);
    cmd_we = 1'b0;
    if (d == 8'h60) begin
      if (mst == 0) mst = 1;
      else if (mst == 1) mst = 2;
      else mlock[esec(a)] = ~a[6];
    end else mst = 0;
  endtask

  task automatic q(input bit [21:0] a, input string req);
    bit [7:0] exp_code;
    query_addr = a;
    #1;
    exp_code = {7'd0, mprot()[esec(a)]};
    chk(query_sector == 8'(esec(a)), $sformatf("R5 %s sector @%h act %0d exp %0d", req, a, query_sector, esec(a)));
    chk(query_bank == a[21:20], $sformatf("R6 %s bank @%h act %0d exp %0d", req, a, query_bank, a[21:20]));
    chk(query_code == exp_code, $sformatf("R8 %s code @%h act %h exp %h", req, a, query_code, exp_code));
  endtask

  task automatic op(input bit [1:0] k, input bit [21:0] a, input string req);
    bit [NS-1:0] p, em;
    bit eg, er;
    int s;
    @(negedge clk);
    op_valid = 1'b1; op_kind = k; op_addr = a;
    p = mprot(); s = esec(a); em = '0; eg = 0; er = 0;
    case (k)
      2'd0: begin eg = !p[s]; er = p[s]; end
      2'd1: begin eg = !p[s]; er = p[s]; if (eg) em[s] = 1'b1; end
      2'd2: begin em = ~p; eg = (em != '0); er = (em == '0); end
      default: ;
    endcase
    @(negedge clk);
    op_valid = 1'b0;
    chk(op_grant == eg && op_reject == er,
        $sformatf("%s kind %0d @%h grant/reject act %b%b exp %b%b", req, k, a, op_grant, op_reject, eg, er));
    chk(erase_mask == em, $sformatf("%s kind %0d mask act %h exp %h", req, k, erase_mask, em));
    @(negedge clk);
    chk(!op_grant && !op_reject && erase_mask == '0,
        $sformatf("R9 pulse width act %b%b exp 00", op_grant, op_reject));
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: run did not complete");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5EED));
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state, R5/R6 map edges
    q(22'h000000, "R1"); q(22'h006000, "R1"); q(22'h008000, "R1");
    q(22'h0FFFFF, "R1"); q(22'h3F0000, "R1"); q(22'h3F8000, "R1");
    q(22'h3FE000, "R1"); q(22'h2A1234, "R1");
    chk(query_code == 8'h01, $sformatf("R1 locked after reset act %h exp 01", query_code));
    op(2'd2, 22'h0, "R10 all locked");
    // R2 unlock sector 4 and R3 repeat without re-entry
    wr(22'h000555, 8'h60); wr(22'h0002AA, 8'h60); wr(22'h008040, 8'h60);
    q(22'h008000, "R2 unlock");
    chk(query_code == 8'h00, $sformatf("R2 sector 4 unlocked act %h exp 00", query_code));
    q(22'h000000, "R2 neighbour");
    wr(22'h3FE040, 8'h60); wr(22'h001040, 8'h60);
    q(22'h3FFFFF, "R3 repeat"); q(22'h001000, "R3 repeat");
    wr(22'h001000, 8'h60);
    q(22'h001000, "R3 relock");
    chk(query_code == 8'h01, $sformatf("R3 relock act %h exp 01", query_code));
    wr(22'h000000, 8'hF0); wr(22'h3FA040, 8'h60);
    q(22'h3FA000, "R3 after exit");
    chk(query_code == 8'h01, $sformatf("R3 no change after exit act %h exp 01", query_code));
    // R4 abort
    wr(22'h0, 8'h60); wr(22'h0, 8'h12); wr(22'h3F8040, 8'h60);
    q(22'h3F8000, "R4 abort");
    chk(query_code == 8'h01, $sformatf("R4 no change after abort act %h exp 01", query_code));
    wr(22'h0, 8'hF0);
    // R9 operations
    op(2'd0, 22'h008123, "R9 prog unlocked");
    op(2'd1, 22'h00F000, "R9 erase unlocked");
    op(2'd1, 22'h010000, "R9 erase locked");
    op(2'd0, 22'h3FFFF0, "R9 prog boot");
    op(2'd3, 22'h008000, "R9 no op");
    op(2'd2, 22'h0, "R10 chip erase");
    // R7 pin override and retention
    @(negedge clk); wp_n = 1'b0;
    q(22'h008000, "R7 pin low");
    chk(query_code == 8'h01, $sformatf("R7 pin protects act %h exp 01", query_code));
    op(2'd0, 22'h008000, "R7 prog pin low");
    op(2'd2, 22'h0, "R7 chip pin low");
    @(negedge clk); wp_n = 1'b1;
    q(22'h008000, "R7 bits retained");
    chk(query_code == 8'h00, $sformatf("R7 lock bit kept act %h exp 00", query_code));
    // random mix
    for (int i = 0; i < 2500; i++) begin
      int r;
      r = $urandom % 10;
      if (r < 5) begin
        bit [7:0] d;
        bit [21:0] a;
        int c;
        c = $urandom % 10;
        d = (c < 7) ? 8'h60 : (c < 8) ? 8'hF0 : 8'($urandom);
        a = raddr();
        wr(a, d);
        q(a, "R2 R3 R4 random");
      end else if (r < 7) q(raddr(), "random query");
      else if (r < 9) op(2'($urandom), raddr(), "R9 R10 random");
      else begin @(negedge clk); wp_n = ($urandom % 4) != 0; end
    end
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule